// File: doc/BRIEF.md
# Quarter-Wave Interpolating Sine/Cosine Oscillator

This block is a numerically controlled oscillator. It generates a pair of signed sine and cosine samples from a running phase accumulator. On every enabled clock the accumulator advances by a programmable tuning word. The accumulator is typically set up to produce a colour-subcarrier reference near 3.579545 MHz from a 50 MHz clock. A phase-offset input is summed with the accumulator on the way to the lookup. A phase-tracking loop can use it to steer the output phase without disturbing the accumulator itself.

The sinusoid is held as a single quarter period of 2^ADDR_W + 1 points, which is far coarser than the phase resolution. Quadrant symmetry rebuilds the rest of the wave. The address is mirrored in the second and fourth quarters, and the result is negated in the lower half. The phase bits below the table address interpolate linearly between two neighbouring entries. The cosine path is the same lookup, applied to the phase advanced by a quarter turn. Each enabled cycle produces one result pair, 3 clocks later, flagged by a valid output.

Top module: `qwave_nco`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `valid_o` is 0 and `sin_o` and `cos_o` are 0. The accumulator restarts at 0.
- R2: Each cycle with `en_i` high adds `tune_i` to the 32-bit accumulator, modulo 2^32. The sample taken that cycle uses the accumulator value from before the addition.
- R3: A cycle with `en_i` low leaves the accumulator unchanged and yields no result, so no `valid_o` pulse follows from it.
- R4: The sample phase is P = accumulator + `phase_ofs_i` (mod 2^32). The offset is never stored: once it returns to 0, the output follows the accumulator alone.
- R5: Only the top 18 bits of P are used. P[31:30] is the quadrant q, P[29:22] is the table address a, and P[21:14] is the fraction f. P[13:0] has no effect on the output.
- R6: The table entry is T[k] = round(2047 * sin(pi*k/512)) for k = 0..256, rounding halves upward. Every output stays within -2047..2047.
- R7: Let L(b,n,f) = b + floor((n-b)*f/256). In quadrants 0 and 2 the magnitude is L(T[a],T[a+1],f). In quadrants 1 and 3 it is L(T[256-a],T[255-a],f). `sin_o` is the magnitude for q = 0 or 1 and its negation for q = 2 or 3, in 12-bit two's complement.
- R8: `cos_o` equals the R7 result for the phase P + 2^30 (mod 2^32).
- R9: The result for a phase sampled at rising edge k is on `sin_o`/`cos_o`, with `valid_o` high, right after rising edge k+2. `valid_o` is high exactly for enabled input cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance the accumulator and take a sample |
| tune_i | input | 32 | Phase increment per enabled cycle |
| phase_ofs_i | input | 32 | Phase offset summed after the accumulator |
| sin_o | output | 12 | Sine sample, two's complement |
| cos_o | output | 12 | Cosine sample, two's complement |
| valid_o | output | 1 | Sample pair valid |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator, an 8-bit table address, an 8-bit fraction and 12-bit samples. At these sizes the offset input can place the phase directly on every quadrant boundary and on the last table address with the full fraction, which exercises the mirrored endpoint. A large tuning word wraps the 32-bit accumulator within a few cycles. A subcarrier-rate tuning word then sweeps the phase through hundreds of distinct table and fraction combinations, while gaps in the enable pattern test the valid alignment.

// File: rtl/qnco_pkg.sv
package qnco_pkg;

  // Quarter-wave table point k of a table with 2^addr_w steps per quarter
  function automatic int qtr_entry(int k, int addr_w, int out_w);
    real amp;
    real ang;
    amp = real'((1 << (out_w - 1)) - 1);
    ang = 1.5707963267948966 * real'(k) / real'(1 << addr_w);
    return $rtoi(amp * $sin(ang) + 0.5);
  endfunction

  // Linear step from b toward n by f / 2^fw, rounded toward minus infinity
  function automatic int qnco_lerp(int b, int n, int f, int fw);
    return b + (((n - b) * f) >>> fw);
  endfunction

endpackage

// File: rtl/qnco_phase_acc.sv
module qnco_phase_acc #(
  parameter int ACC_W = 32,
  parameter int USE_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [ACC_W-1:0] tune_i,
  input  logic [ACC_W-1:0] ofs_i,
  output logic [USE_W-1:0] phase_o,
  output logic             v_o
);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;

  assign sum = acc + ofs_i;

  wire unused_low_phase = &{1'b0, sum[ACC_W-USE_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      phase_o <= '0;
      v_o     <= 1'b0;
    end else begin
      v_o <= en_i;
      if (en_i) begin
        acc     <= acc + tune_i;
        phase_o <= sum[ACC_W-1 -: USE_W];
      end
    end
  end

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    en_i |=> acc == $past(acc) + $past(tune_i)); // R2
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(acc)); // R3

endmodule

// File: rtl/qnco_lookup.sv
module qnco_lookup
  import qnco_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 12,
  localparam int USE_W = 2 + ADDR_W + FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    v_i,
  input  logic [USE_W-1:0]        phase_i,
  output logic signed [OUT_W-1:0] base_o,
  output logic signed [OUT_W-1:0] next_o,
  output logic [FRAC_W-1:0]       frac_o,
  output logic                    neg_o,
  output logic                    v_o
);

  localparam int TOP   = 1 << ADDR_W;
  localparam int TBL_N = TOP + 1;

  logic signed [OUT_W-1:0] tbl [TBL_N];

  for (genvar k = 0; k < TBL_N; k++) begin : g_tbl
    assign tbl[k] = OUT_W'(qtr_entry(k, ADDR_W, OUT_W));
  end

  logic [1:0]        quad;
  logic [ADDR_W-1:0] addr;
  logic [FRAC_W-1:0] frac;
  logic              mirror;
  logic [ADDR_W:0]   idx_b;
  logic [ADDR_W:0]   idx_n;
  logic              mir_q;

  assign quad   = phase_i[USE_W-1 -: 2];
  assign addr   = phase_i[USE_W-3 -: ADDR_W];
  assign frac   = phase_i[FRAC_W-1:0];
  assign mirror = quad[0];

  always_comb begin
    if (mirror) begin
      idx_b = (ADDR_W+1)'(TOP) - {1'b0, addr};
      idx_n = (ADDR_W+1)'(TOP - 1) - {1'b0, addr};
    end else begin
      idx_b = {1'b0, addr};
      idx_n = {1'b0, addr} + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_o <= '0;
      next_o <= '0;
      frac_o <= '0;
      neg_o  <= 1'b0;
      mir_q  <= 1'b0;
      v_o    <= 1'b0;
    end else begin
      base_o <= tbl[idx_b];
      next_o <= tbl[idx_n];
      frac_o <= frac;
      neg_o  <= quad[1];
      mir_q  <= mirror;
      v_o    <= v_i;
    end
  end

  // Mirrored reads walk down the quarter wave, direct reads walk up
  AST_SLOPE_DIR: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (mir_q ? (next_o <= base_o) : (next_o >= base_o))); // R7

endmodule

// File: rtl/qnco_interp.sv
module qnco_interp
  import qnco_pkg::*;
#(
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    v_i,
  input  logic signed [OUT_W-1:0] base_i,
  input  logic signed [OUT_W-1:0] next_i,
  input  logic [FRAC_W-1:0]       frac_i,
  input  logic                    neg_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    v_o
);

  localparam int AMP = (1 << (OUT_W - 1)) - 1;

  int mag;
  int val;

  always_comb begin
    mag = qnco_lerp(int'(base_i), int'(next_i), int'(frac_i), FRAC_W);
    val = neg_i ? -mag : mag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= '0;
      v_o      <= 1'b0;
    end else begin
      sample_o <= OUT_W'(val);
      v_o      <= v_i;
    end
  end

  AST_AMP_BOUND: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (int'(sample_o) <= AMP && int'(sample_o) >= -AMP)); // R6
  AST_HALF_SIGN: assert property (@(posedge clk) disable iff (rst)
    v_i |=> ($past(neg_i) ? sample_o <= 0 : sample_o >= 0)); // R7

endmodule

// File: rtl/qwave_nco.sv
module qwave_nco #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 8,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [ACC_W-1:0] tune_i,
  input  logic [ACC_W-1:0] phase_ofs_i,
  output logic [OUT_W-1:0] sin_o,
  output logic [OUT_W-1:0] cos_o,
  output logic             valid_o
);

  localparam int USE_W = 2 + ADDR_W + FRAC_W;
  localparam logic [USE_W-1:0] QUARTER = USE_W'(1) << (USE_W - 2);

  logic [USE_W-1:0] ph_s1;
  logic             v_s1;
  logic [USE_W-1:0] ch_ph [2];
  logic [OUT_W-1:0] ch_out [2];
  logic [1:0]       ch_vld;

  qnco_phase_acc #(.ACC_W(ACC_W), .USE_W(USE_W)) u_acc (
    .clk(clk), .rst(rst), .en_i(en_i), .tune_i(tune_i),
    .ofs_i(phase_ofs_i), .phase_o(ph_s1), .v_o(v_s1)
  );

  assign ch_ph[0] = ph_s1;
  assign ch_ph[1] = ph_s1 + QUARTER;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic signed [OUT_W-1:0] base_s2;
    logic signed [OUT_W-1:0] next_s2;
    logic [FRAC_W-1:0]       frac_s2;
    logic                    neg_s2;
    logic                    v_s2;
    logic signed [OUT_W-1:0] samp;

    qnco_lookup #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_lut (
      .clk(clk), .rst(rst), .v_i(v_s1), .phase_i(ch_ph[ch]),
      .base_o(base_s2), .next_o(next_s2), .frac_o(frac_s2),
      .neg_o(neg_s2), .v_o(v_s2)
    );

    qnco_interp #(.FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_int (
      .clk(clk), .rst(rst), .v_i(v_s2), .base_i(base_s2),
      .next_i(next_s2), .frac_i(frac_s2), .neg_i(neg_s2),
      .sample_o(samp), .v_o(ch_vld[ch])
    );

    assign ch_out[ch] = samp;
  end

  assign sin_o   = ch_out[0];
  assign cos_o   = ch_out[1];
  assign valid_o = ch_vld[0];

  wire unused_cos_vld = ch_vld[1];

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(en_i, 3)); // R9
  AST_IDLE_VALID: assert property (@(posedge clk) disable iff (rst)
    !$past(en_i, 3) |-> !valid_o); // R3

endmodule

// File: tb/tb_qwave_nco.sv
module tb_qwave_nco;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_i = 1'b0;
  logic [31:0] tune_i = '0;
  logic [31:0] phase_ofs_i = '0;
  logic [11:0] sin_o;
  logic [11:0] cos_o;
  logic        valid_o;

  qwave_nco dut (
    .clk(clk), .rst(rst), .en_i(en_i), .tune_i(tune_i),
    .phase_ofs_i(phase_ofs_i), .sin_o(sin_o), .cos_o(cos_o), .valid_o(valid_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    int cyc;
    int s;
    int c;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;
  logic [31:0] macc = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // R6 table point
  function automatic int tpt(int k);
    return $rtoi(2047.0 * $sin(3.141592653589793 * k / 512.0) + 0.5);
  endfunction

  // R5 field split, R7 quadrant rule
  function automatic int wave(logic [31:0] p);
    int q;
    int a;
    int f;
    int lo;
    int hi;
    int m;
    q = int'(p[31:30]);
    a = int'(p[29:22]);
    f = int'(p[21:14]);
    case (q)
      0, 2: begin lo = tpt(a); hi = tpt(a + 1); end
      default: begin lo = tpt(256 - a); hi = tpt(255 - a); end
    endcase
    m = lo + (((hi - lo) * f) >>> 8);
    return (q >= 2) ? -m : m;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Driver: applies one cycle and records the expected result
  task automatic step(bit en, logic [31:0] tune, logic [31:0] ofs);
    exp_t e;
    @(negedge clk);
    en_i = en;
    tune_i = tune;
    phase_ofs_i = ofs;
    if (en) begin
      e.cyc = cyc;
      e.s = wave(macc + ofs);
      e.c = wave(macc + ofs + 32'h4000_0000); // R8
      sb.push_back(e);
      macc = macc + tune; // R2
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (valid_o) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R3 unexpected valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cyc == e.cyc + 3, "R9 latency", cyc - e.cyc, 3);
          chk(int'($signed(sin_o)) == e.s, "R7 sine", int'($signed(sin_o)), e.s);
          chk(int'($signed(cos_o)) == e.c, "R8 cosine", int'($signed(cos_o)), e.c);
        end
      end else if (sb.size() != 0 && sb[0].cyc + 3 <= cyc) begin
        chk(1'b0, "R9 missing valid", 0, 1);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] sub_tune;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(valid_o == 1'b0, "R1 valid in reset", int'(valid_o), 0);
    chk(sin_o == '0, "R1 sine in reset", int'(sin_o), 0);
    chk(cos_o == '0, "R1 cosine in reset", int'(cos_o), 0);
    @(negedge clk);
    rst = 1'b0;
    chk(valid_o == 1'b0 && sin_o == '0, "R1 first cycle after reset", int'(valid_o), 0);

    // R5 R7 directed phases: boundaries, top address with full fraction
    step(1, 0, 32'h0000_0000);
    step(1, 0, 32'h4000_0000);
    step(1, 0, 32'h8000_0000);
    step(1, 0, 32'hC000_0000);
    step(1, 0, 32'h3FFF_C000);
    step(1, 0, 32'h7FFF_C000);
    step(1, 0, 32'hBFFF_C000);
    step(1, 0, 32'hFFFF_C000);
    step(1, 0, 32'h0040_0000);
    step(1, 0, 32'h5A5A_4000);
    // R5 low 14 bits ignored: same upper bits, different low bits
    step(1, 0, 32'h1234_4000);
    step(1, 0, 32'h1234_7FFF);
    step(1, 0, 32'h1234_5A5A);
    repeat (4) step(0, 0, 0);

    // R2 R9 subcarrier tuning with R3 enable gaps
    sub_tune = 32'($rtoi(3.579545e6 / 50.0e6 * 4294967296.0));
    for (int i = 0; i < 300; i++) step((i % 7) != 3, sub_tune, 0);

    // R4 offset nudges, then removed
    for (int i = 0; i < 30; i++) step(1, sub_tune, 32'h2000_1234 + 32'(i) * 32'h0100_0000);
    for (int i = 0; i < 30; i++) step(1, sub_tune, 0);

    // R2 wrap with a large tuning word
    for (int i = 0; i < 60; i++) step(1, 32'hF123_4567, 0);

    // R3 disabled stretch keeps the accumulator, then resume
    for (int i = 0; i < 12; i++) step(0, 32'h7777_7777, 32'h1111_0000);
    for (int i = 0; i < 20; i++) step(1, 32'h0009_3A00, 0);
    repeat (6) step(0, 0, 0);

    chk(sb.size() == 0, "R9 results outstanding", sb.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule